// File: doc/BRIEF.md
# Host Port Prefetching Access Controller

This block serves a host that talks through a chip-select style port and turns each host transaction into a request on a local memory port. The host address, direction and write data are captured on the cycle that chip select is first seen low. The block runs the memory access and answers with a one-cycle ready pulse. Read data stays on the host data output from that pulse onward.

Two mode inputs can make the block look ahead. With look-ahead on, it fetches the word after the one just accessed into a single-entry holding buffer. Depending on the mode, this happens after reads or after writes. A later host read whose captured address matches the buffered address is answered straight from the buffer, with no memory request. Every access still uses its own captured address, so random accesses stay correct in every mode. A host access that arrives while a prefetch is running waits until the prefetch ends, and is then checked against the refreshed buffer.

Top module: `hpf_ctrl`

## Requirements
- R1: After reset, host_rdy and mem_req are low and the buffer is empty, so the first host read issues one memory read.
- R2: Every host access uses the address captured when chip select falls. Read data equals the memory content at that address, in every mode.
- R3: With inc_en low, no prefetch is issued after any read or write, whatever pf_on_wr is.
- R4: Block mode (inc_en=1, pf_on_wr=0): each host read, hit or miss, is followed by exactly one memory read of the captured address plus one. No prefetch follows a write.
- R5: Modify mode (inc_en=1, pf_on_wr=1): each host write is followed by exactly one memory read of the captured address plus one. No prefetch follows a read.
- R6: A host read whose captured address equals the address of valid buffered data completes with no memory request, and returns the buffered word.
- R7: A host write to the buffered address replaces the buffered word with the written data, so a later hit returns the new value.
- R8: Any change of {inc_en, pf_on_wr} empties the buffer. The next read of the formerly buffered address issues a memory read.
- R9: host_rdy is high for exactly one cycle per transaction, and stays low while that transaction's memory request is outstanding.
- R10: At most one memory request is outstanding. Once mem_req is raised, it and mem_addr stay unchanged until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_en | input | 1 | Look-ahead enable (mode bit) |
| pf_on_wr | input | 1 | 1: prefetch after writes; 0: after reads (mode bit) |
| host_cs_n | input | 1 | Host chip select, active low, held low until host_rdy |
| host_we | input | 1 | 1 = write, 0 = read; sampled when chip select falls |
| host_addr | input | AW | Word address; sampled when chip select falls |
| host_wdata | input | DW | Write data; sampled when chip select falls |
| host_rdata | output | DW | Read data, valid from the host_rdy pulse |
| host_rdy | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write strobe qualifier |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | One-cycle completion from memory; mem_rdata valid with it |
| mem_rdata | input | DW | Memory read data |

## Verification
The assertions assume a well-behaved host and memory. The host keeps chip select low until it sees ready, then releases it for at least one cycle before its next access. The memory pulses mem_ack only while mem_req is high, and only for one cycle. The mode bits are assumed to change only between transactions. The bench host task and the latency-randomising memory model follow these rules by construction. The bench picks a new mode only after the previous transaction and its prefetch have settled.

// File: rtl/hpf_pkg.sv
// Shared types for the host prefetch controller.
package hpf_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,  // waiting for a pending host access
        S_MEM  = 2'd1,  // host-owned memory access outstanding
        S_RESP = 2'd2,  // ready pulse to host
        S_PREF = 2'd3   // look-ahead read outstanding
    } hpf_state_t;
endpackage

// File: rtl/hpf_mode_dec.sv
// Decodes the two mode inputs into prefetch triggers.
// Assumes the inputs are synchronous to clk.
module hpf_mode_dec (
    input  logic inc_en,
    input  logic pf_on_wr,
    output logic pf_after_rd,
    output logic pf_after_wr
);
    // Look-ahead only when increment is on; the second bit picks the trigger.
    always_comb begin
        pf_after_rd = inc_en & ~pf_on_wr;
        pf_after_wr = inc_en &  pf_on_wr;
    end
endmodule

// File: rtl/hpf_buffer.sv
// Single-entry look-ahead holding buffer with address compare.
// A load fills it, a host write to the held address refreshes the data,
// and clr empties it. Assumes load and clr are never high together.
module hpf_buffer #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          wr_upd,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] lk_addr,
    output logic          hit,
    output logic [DW-1:0] q_data
);
    logic          valid_q;
    logic [AW-1:0] addr_q;

    // Valid flag: set by a load, cleared by reset or mode change.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) valid_q <= 1'b0;
        else if (load)     valid_q <= 1'b1;
    end

    // Address and data storage; a host write to the held word refreshes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            q_data <= '0;
        end else if (load) begin
            addr_q <= ld_addr;
            q_data <= ld_data;
        end else if (wr_upd && valid_q && wr_addr == addr_q) begin
            q_data <= wr_data;
        end
    end

    // Hit compare against the captured host address.
    always_comb hit = valid_q && (lk_addr == addr_q);

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid_q);
    // R7
    write_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_upd && valid_q && wr_addr == addr_q && !load && !clr) |=> (q_data == $past(wr_data)));
endmodule

// File: rtl/hpf_ctrl.sv
// Host port access controller with sequential look-ahead.
// Captures the host request on the falling edge of chip select and serves it
// from the look-ahead buffer (read hit) or from memory. It may then fetch
// the next word into the buffer. Assumes the host holds chip select low until
// host_rdy and the memory acks once per request.
module hpf_ctrl #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_en,
    input  logic          pf_on_wr,
    input  logic          host_cs_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    import hpf_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(1);

    hpf_state_t    state_q;
    logic          cs_q, cs_fall;
    logic          pend_q, req_we_q;
    logic [AW-1:0] req_addr_q, pf_tgt_q;
    logic [DW-1:0] req_wdata_q;
    logic [1:0]    mode_q;
    logic          mode_chg, pf_kill_q;
    logic          pf_after_rd, pf_after_wr, pf_go;
    logic          buf_hit, buf_load, buf_wr;
    logic [DW-1:0] buf_data;

    hpf_mode_dec u_dec (
        .inc_en      (inc_en),
        .pf_on_wr    (pf_on_wr),
        .pf_after_rd (pf_after_rd),
        .pf_after_wr (pf_after_wr)
    );

    always_comb begin
        cs_fall  = !host_cs_n && cs_q;
        mode_chg = {inc_en, pf_on_wr} != mode_q;
        pf_go    = req_we_q ? pf_after_wr : pf_after_rd;
        buf_load = (state_q == S_PREF) && mem_ack && !pf_kill_q && !mode_chg;
        buf_wr   = (state_q == S_MEM) && mem_ack && req_we_q;
    end

    hpf_buffer #(.AW(AW), .DW(DW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_chg),
        .load    (buf_load),
        .ld_addr (pf_tgt_q),
        .ld_data (mem_rdata),
        .wr_upd  (buf_wr),
        .wr_addr (req_addr_q),
        .wr_data (req_wdata_q),
        .lk_addr (req_addr_q),
        .hit     (buf_hit),
        .q_data  (buf_data)
    );

    // Chip-select edge detector and mode history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            mode_q <= 2'b00;
        end else begin
            cs_q   <= host_cs_n;
            mode_q <= {inc_en, pf_on_wr};
        end
    end

    // Host request capture on the falling edge of chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
        end else if (cs_fall) begin
            pend_q      <= 1'b1;
            req_we_q    <= host_we;
            req_addr_q  <= host_addr;
            req_wdata_q <= host_wdata;
        end else if (state_q == S_RESP) begin
            pend_q      <= 1'b0;
        end
    end

    // Main sequencer: serve, respond, then optionally look ahead.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            pf_tgt_q   <= '0;
            pf_kill_q  <= 1'b0;
            host_rdata <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (pend_q) begin
                    if (!req_we_q && buf_hit) begin
                        host_rdata <= buf_data;
                        state_q    <= S_RESP;
                    end else begin
                        state_q    <= S_MEM;
                    end
                end
                S_MEM: if (mem_ack) begin
                    if (!req_we_q) host_rdata <= mem_rdata;
                    state_q <= S_RESP;
                end
                S_RESP: begin
                    pf_tgt_q  <= req_addr_q + STEP;
                    pf_kill_q <= 1'b0;
                    state_q   <= pf_go ? S_PREF : S_IDLE;
                end
                S_PREF: begin
                    if (mode_chg) pf_kill_q <= 1'b1;
                    if (mem_ack)  state_q   <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Memory port and host ready decode from the sequencer state.
    always_comb begin
        mem_req   = (state_q == S_MEM) || (state_q == S_PREF);
        mem_we    = (state_q == S_MEM) && req_we_q;
        mem_addr  = (state_q == S_PREF) ? pf_tgt_q : req_addr_q;
        mem_wdata = req_wdata_q;
        host_rdy  = (state_q == S_RESP);
    end

    // R9
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |=> !host_rdy);
    // R9
    rdy_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rdy && mem_req));
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R6
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && pend_q && !req_we_q && buf_hit) |=> (host_rdy && !mem_req));
    // R3
    no_pref_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdy && !inc_en) |=> !mem_req);
endmodule

// File: tb/tb_hpf_ctrl.sv
module tb_hpf_ctrl;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inc_en = 1'b0, pf_on_wr = 1'b0;
    logic          host_cs_n = 1'b1, host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rdy, mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    hpf_ctrl #(.AW(AW), .DW(DW)) dut (.*);

    int checks = 0, fails = 0;
    logic [DW-1:0] mem_m [0:63];
    logic [DW-1:0] shadow [0:63];
    int            acc_cnt = 0;
    logic [AW-1:0] last_acc_addr = '0;
    logic          last_acc_we = 1'b0;
    int            lat_q = 0;
    logic          pfv = 1'b0;
    logic [AW-1:0] pfa = '0;
    logic [1:0]    cur_mode = 2'b00;

    function automatic logic [DW-1:0] init_word(int i);
        return (i * 32'h01010101) ^ 32'hA500_0000;
    endfunction

    // Memory model with random latency, one-cycle ack.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat_q   <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_q   <= $urandom % 3;
        end else if (mem_req) begin
            if (lat_q == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_m[mem_addr[5:0]];
                if (mem_we) mem_m[mem_addr[5:0]] <= mem_wdata;
                acc_cnt       <= acc_cnt + 1;
                last_acc_addr <= mem_addr;
                last_acc_we   <= mem_we;
            end else begin
                lat_q <= lat_q - 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        if (m != cur_mode) pfv = 1'b0;
        cur_mode = m;
        {inc_en, pf_on_wr} = m;
        repeat (2) @(negedge clk);
    endtask

    // One host transaction followed by a settle window; checks against model.
    task automatic txn(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input bit settle);
        int  c0, c1;
        bit  hit, go;
        logic [DW-1:0] rd;
        hit = !we && pfv && (pfa == a);
        @(negedge clk);
        c0 = acc_cnt;
        host_cs_n = 1'b0; host_we = we; host_addr = a; host_wdata = wd;
        do @(negedge clk); while (!host_rdy);
        rd = host_rdata;
        c1 = acc_cnt;
        host_cs_n = 1'b1;
        if (!we) check(rd == shadow[a[5:0]], "R2 read data", rd, shadow[a[5:0]]);
        else shadow[a[5:0]] = wd;
        if (settle)
            check((c1 - c0) == (hit ? 0 : 1), hit ? "R6 hit access count" : "R1 miss access count",
                  DW'(c1 - c0), DW'(hit ? 0 : 1));
        @(negedge clk);
        check(!host_rdy, "R9 ready single cycle", DW'(host_rdy), '0);
        go = inc_en && (we == pf_on_wr);
        if (settle) begin
            repeat (8) @(negedge clk);
            check((acc_cnt - c1) == (go ? 1 : 0),
                  !inc_en ? "R3 prefetch count" : (pf_on_wr ? "R5 prefetch count" : "R4 prefetch count"),
                  DW'(acc_cnt - c1), DW'(go ? 1 : 0));
            if (go)
                check(last_acc_addr == a + 1 && !last_acc_we, "R4 R5 prefetch address",
                      DW'(last_acc_addr), DW'(a + 1));
        end
        if (go) begin pfv = 1'b1; pfa = a + 1; end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem_m[i]  = init_word(i);
            shadow[i] = init_word(i);
        end
        mem_rdata = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!host_rdy && !mem_req, "R1 reset outputs", {30'd0, host_rdy, mem_req}, '0);
        rst_n = 1'b1;
        // R1 first read misses; R3 no prefetch with increment off
        txn(1'b0, 16'd5, '0, 1'b1);
        set_mode(2'b01);
        txn(1'b0, 16'd6, '0, 1'b1);   // R3 with pf_on_wr high
        txn(1'b1, 16'd7, 32'h1111_2222, 1'b1);
        // R4 block mode: read prefetch, hit, write no prefetch
        set_mode(2'b10);
        txn(1'b0, 16'd5, '0, 1'b1);
        txn(1'b0, 16'd6, '0, 1'b1);   // R6 hit, chained prefetch of 7
        txn(1'b0, 16'd7, '0, 1'b1);   // R6 hit again
        txn(1'b0, 16'd20, '0, 1'b1);  // R2 random access, prefetch 21
        txn(1'b1, 16'd21, 32'hDEAD_BEEF, 1'b1); // R7 write to buffered word
        txn(1'b0, 16'd21, '0, 1'b1);  // R7 hit with new data
        // R5 modify mode
        set_mode(2'b11);              // R8 clears buffer (holding 22)
        txn(1'b0, 16'd22, '0, 1'b1);  // R8 miss, R5 no prefetch after read
        txn(1'b1, 16'd3, 32'hCAFE_0003, 1'b1);
        txn(1'b0, 16'd4, '0, 1'b1);   // R6 hit
        // R10 back-to-back access during prefetch
        txn(1'b1, 16'd30, 32'h0BAD_F00D, 1'b0);
        txn(1'b0, 16'd31, '0, 1'b0);
        txn(1'b0, 16'd30, '0, 1'b1);
        // Random phase
        for (int n = 0; n < 200; n++) begin
            logic [AW-1:0] a;
            if (($urandom % 8) == 0) set_mode(2'($urandom % 4));
            a = (($urandom % 2) == 0 && pfv) ? pfa : AW'($urandom % 40);
            txn(1'($urandom % 3 == 0), a, $urandom, 1'b1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule